// File: doc/BRIEF.md
# DRAM Refresh Address Generator

This block produces the refresh address and strobes that a processor core places on its memory bus between instruction fetches. It holds an 8-bit refresh counter. Each completed opcode fetch advances the lower seven bits of the counter, and the top bit stays at whatever software last wrote. A separate 8-bit page register, the high half of the vectored interrupt base, supplies the upper address byte.

During the decode/execute slot that follows a fetch, the core raises `rfsh_slot`. The block then drives `{page, counter}` onto the 16-bit address bus and pulls both the memory-request and refresh strobes low. Dynamic memories can then take the lower seven address bits as a row to refresh. Both registers can be written from the core's data path. When another bus master owns the bus, the block releases the address bus and keeps both strobes inactive. Row timing for the DRAM itself is generated elsewhere.

Top module: `rfsh_addr_gen`

## Requirements
- R1: After reset, both the refresh counter and the page register read zero, so the first refresh slot drives address 0x0000.
- R2: Each cycle with `fetch_done` high and `ld_rfsh` low adds one to bits 6..0 of the counter at the next clock edge.
- R3: Bit 7 of the counter is never changed by an increment. Only a load alters it.
- R4: Bits 6..0 wrap from 0x7F to 0x00 without disturbing bit 7, so 0xFF steps to 0x80 and 0x7F steps to 0x00.
- R5: `ld_rfsh` writes all eight bits of `wr_data` into the counter at the next clock edge.
- R6: When `ld_rfsh` and `fetch_done` are high in the same cycle, the loaded value is kept and that cycle's increment is lost.
- R7: When `rfsh_slot` is high and `bus_granted` is low, `addr_o[7:0]` equals the counter, `addr_o[15:8]` equals the page register, and `addr_oe` is 1.
- R8: `mreq_n` and `rfsh_n` are both 0 exactly when R7 applies. Otherwise both are 1, `addr_oe` is 0 and `addr_o` reads 0x0000.
- R9: When `bus_granted` is high, the strobes stay 1 and `addr_oe` stays 0 even during a refresh slot. Fetch increments still take effect.
- R10: `ld_page` writes `wr_data` into the page register only. The page register holds its value when `ld_page` is low, and loading it does not change the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_done | input | 1 | One pulse per completed opcode fetch; advances the counter |
| rfsh_slot | input | 1 | High during the decode/execute refresh slot |
| ld_rfsh | input | 1 | Load the refresh counter from `wr_data` |
| ld_page | input | 1 | Load the page register from `wr_data` |
| wr_data | input | 8 | Write data from the core's data path |
| bus_granted | input | 1 | Bus currently owned by another master |
| addr_o | output | 16 | Refresh address {page, counter}; 0 when not driving |
| addr_oe | output | 1 | Address drive enable (0 means high-impedance) |
| mreq_n | output | 1 | Active-low memory request strobe |
| rfsh_n | output | 1 | Active-low refresh strobe |

## Verification
The bench goes after the wrap points 0x7F and 0xFF. A design that carried into bit 7, or let the increment clear it, would show 0x80 or 0x00 in the wrong place. It also collides a load with a fetch in the same cycle, where a design with the wrong priority ends one count high. It raises a refresh slot while the bus is granted away, where a leaky gate would drive strobes onto another master's bus. Long random stretches that mix loads of both registers compare every cycle against a behavioural model, which exposes a page register that drifts or a load that lands in the wrong register.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_STEP = 2'd1,
    CNT_LOAD = 2'd2
  } cnt_op_e;

  // A load outranks a fetch step in the same cycle.
  function automatic cnt_op_e pick_op(logic load, logic step);
    if (load)      return CNT_LOAD;
    else if (step) return CNT_STEP;
    else           return CNT_HOLD;
  endfunction

endpackage

// File: rtl/rfsh_counter.sv
module rfsh_counter
  import rfsh_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             step_evt_o,
  output logic             load_evt_o
);
  localparam int INC_W = CNT_W - 1;

  // Advance the low bits; the top bit is carried unchanged.
  function automatic logic [CNT_W-1:0] advance(logic [CNT_W-1:0] v);
    logic [INC_W-1:0] low;
    low = v[INC_W-1:0] + INC_W'(1);
    return {v[CNT_W-1], low};
  endfunction

  cnt_op_e          op;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign op         = pick_op(load_i, step_i);
  assign step_evt_o = (op == CNT_STEP);
  assign load_evt_o = (op == CNT_LOAD);

  always_comb begin
    unique case (op)
      CNT_LOAD: cnt_d = load_data_i;
      CNT_STEP: cnt_d = advance(cnt_q);
      default:  cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rfsh_page_reg.sv
module rfsh_page_reg #(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [PAGE_W-1:0] load_data_i,
  output logic [PAGE_W-1:0] page_o
);
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      page_q <= '0;
    else if (load_i) page_q <= load_data_i;
  end

  assign page_o = page_q;
endmodule

// File: rtl/rfsh_drive.sv
module rfsh_drive #(
  parameter int CNT_W  = 8,
  parameter int PAGE_W = 8
) (
  input  logic                    slot_i,
  input  logic                    bus_granted_i,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic [PAGE_W-1:0]       page_i,
  output logic [PAGE_W+CNT_W-1:0] addr_o,
  output logic                    addr_oe_o,
  output logic                    mreq_n_o,
  output logic                    rfsh_n_o,
  output logic                    active_o
);
  localparam int ADDR_W = PAGE_W + CNT_W;

  logic [ADDR_W-1:0] src;
  logic              active;

  assign active = slot_i & ~bus_granted_i;
  assign src    = {page_i, cnt_i};

  for (genvar b = 0; b < ADDR_W; b++) begin : g_gate
    assign addr_o[b] = active & src[b];
  end

  assign addr_oe_o = active;
  assign mreq_n_o  = ~active;
  assign rfsh_n_o  = ~active;
  assign active_o  = active;
endmodule

// File: rtl/rfsh_addr_gen.sv
module rfsh_addr_gen #(
  parameter int CNT_W  = 8,
  parameter int PAGE_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fetch_done,
  input  logic                    rfsh_slot,
  input  logic                    ld_rfsh,
  input  logic                    ld_page,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    bus_granted,
  output logic [PAGE_W+CNT_W-1:0] addr_o,
  output logic                    addr_oe,
  output logic                    mreq_n,
  output logic                    rfsh_n
);
  logic [CNT_W-1:0]  cnt_q;
  logic [PAGE_W-1:0] page_q;
  logic              step_evt;
  logic              load_evt;
  logic              drive_evt;

  rfsh_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_i     (fetch_done),
    .load_i     (ld_rfsh),
    .load_data_i(CNT_W'(wr_data)),
    .cnt_o      (cnt_q),
    .step_evt_o (step_evt),
    .load_evt_o (load_evt)
  );

  rfsh_page_reg #(.PAGE_W(PAGE_W)) u_page (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (ld_page),
    .load_data_i(PAGE_W'(wr_data)),
    .page_o     (page_q)
  );

  rfsh_drive #(.CNT_W(CNT_W), .PAGE_W(PAGE_W)) u_drv (
    .slot_i       (rfsh_slot),
    .bus_granted_i(bus_granted),
    .cnt_i        (cnt_q),
    .page_i       (page_q),
    .addr_o       (addr_o),
    .addr_oe_o    (addr_oe),
    .mreq_n_o     (mreq_n),
    .rfsh_n_o     (rfsh_n),
    .active_o     (drive_evt)
  );
endmodule

// File: rtl/rfsh_addr_gen_chk.sv
module rfsh_addr_gen_chk #(
  parameter int CNT_W  = 8,
  parameter int PAGE_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    fetch_done,
  input logic                    ld_rfsh,
  input logic                    ld_page,
  input logic [7:0]              wr_data,
  input logic                    bus_granted,
  input logic [PAGE_W+CNT_W-1:0] addr_o,
  input logic                    addr_oe,
  input logic                    mreq_n,
  input logic                    rfsh_n,
  input logic [CNT_W-1:0]        cnt_q,
  input logic [PAGE_W-1:0]       page_q,
  input logic                    step_evt,
  input logic                    load_evt
);
  localparam int INC_W = CNT_W - 1;

  // R2
  low_bits_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_done && !ld_rfsh) |=>
      cnt_q[INC_W-1:0] == INC_W'($past(cnt_q[INC_W-1:0]) + 1'b1));

  // R3
  msb_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> cnt_q[CNT_W-1] == $past(cnt_q[CNT_W-1]));

  // R6
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> cnt_q == CNT_W'($past(wr_data)));

  // R7
  refresh_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rfsh_n |-> (addr_oe && addr_o == {page_q, cnt_q}));

  // R8
  strobes_paired_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_n == mreq_n);

  // R9
  granted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_granted |-> (rfsh_n && mreq_n && !addr_oe));

  // R10
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_page |=> $stable(page_q));
endmodule

bind rfsh_addr_gen rfsh_addr_gen_chk #(.CNT_W(CNT_W), .PAGE_W(PAGE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fetch_done (fetch_done),
  .ld_rfsh    (ld_rfsh),
  .ld_page    (ld_page),
  .wr_data    (wr_data),
  .bus_granted(bus_granted),
  .addr_o     (addr_o),
  .addr_oe    (addr_oe),
  .mreq_n     (mreq_n),
  .rfsh_n     (rfsh_n),
  .cnt_q      (cnt_q),
  .page_q     (page_q),
  .step_evt   (step_evt),
  .load_evt   (load_evt)
);

// File: tb/test_rfsh_addr_gen.sv
module test_rfsh_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_done = 1'b0;
  logic        rfsh_slot = 1'b0;
  logic        ld_rfsh = 1'b0;
  logic        ld_page = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        bus_granted = 1'b0;
  logic [15:0] addr_o;
  logic        addr_oe;
  logic        mreq_n;
  logic        rfsh_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural reference state
  int m_cnt = 0;
  int m_page = 0;

  always #5 clk = ~clk;

  rfsh_addr_gen i_rfsh_addr_gen (
    .clk(clk), .rst_n(rst_n), .fetch_done(fetch_done), .rfsh_slot(rfsh_slot),
    .ld_rfsh(ld_rfsh), .ld_page(ld_page), .wr_data(wr_data),
    .bus_granted(bus_granted), .addr_o(addr_o), .addr_oe(addr_oe),
    .mreq_n(mreq_n), .rfsh_n(rfsh_n)
  );

  task automatic compare(string req);
    bit drv;
    int exp_addr;
    drv = rfsh_slot && !bus_granted;
    exp_addr = drv ? (m_page * 256 + m_cnt) : 0;
    checks++;
    if (int'(addr_o) != exp_addr || addr_oe != drv || mreq_n != !drv || rfsh_n != !drv) begin
      errors++;
      $display("FAIL %s: addr=%h oe=%b mreq_n=%b rfsh_n=%b expected addr=%h oe=%b strobes=%b",
               req, addr_o, addr_oe, mreq_n, rfsh_n, exp_addr[15:0], drv, !drv);
    end
  endtask

  task automatic step(input bit f, input bit s, input bit lr, input bit lp,
                      input int d, input bit bg, input string req);
    fetch_done = f; rfsh_slot = s; ld_rfsh = lr; ld_page = lp;
    wr_data = d[7:0]; bus_granted = bg;
    #1;
    compare(req);
    @(posedge clk);
    if (lr)     m_cnt = d % 256;
    else if (f) m_cnt = (m_cnt / 128) * 128 + ((m_cnt % 128) + 1) % 128;
    if (lp)     m_page = d % 256;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state visible on first refresh slot
    step(0, 1, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, 0, "R8");
    // R2: three fetches
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0, "R2");
    step(0, 1, 0, 0, 0, 0, "R2");
    // R10: page load, counter untouched
    step(0, 0, 0, 1, 'h5A, 0, "R10");
    step(0, 1, 0, 0, 0, 0, "R7");
    // R5 / R3 / R4: wrap with bit 7 set
    step(0, 0, 1, 0, 'hFD, 0, "R5");
    step(1, 1, 0, 0, 0, 0, "R3");
    step(1, 1, 0, 0, 0, 0, "R3");
    step(1, 1, 0, 0, 0, 0, "R4");
    step(0, 1, 0, 0, 0, 0, "R4");
    // R4: wrap with bit 7 clear
    step(0, 0, 1, 0, 'h7E, 0, "R5");
    step(1, 1, 0, 0, 0, 0, "R4");
    step(1, 1, 0, 0, 0, 0, "R4");
    step(0, 1, 0, 0, 0, 0, "R4");
    // R6: load and fetch together
    step(1, 0, 1, 0, 'h40, 0, "R6");
    step(0, 1, 0, 0, 0, 0, "R6");
    // R9: bus granted away during slot; increment still counts
    step(1, 1, 0, 0, 0, 1, "R9");
    step(0, 1, 0, 0, 0, 1, "R9");
    step(0, 1, 0, 0, 0, 0, "R9");
    // random mix
    for (int i = 0; i < 400; i++)
      step($urandom_range(1), $urandom_range(1), ($urandom_range(7) == 0),
           ($urandom_range(7) == 0), $urandom_range(255), ($urandom_range(5) == 0), "R7");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule